// File: doc/BRIEF.md
# Microsecond Compare Timer

This block is a free-running system timer with four compare channels, reached through a plain 32-bit register bus. A 64-bit count advances by one on every tick. An internal divider produces the tick from the system clock, and its ratio is a parameter chosen so that the count advances once per microsecond. Each channel holds a 32-bit compare value. On a tick where the new low half of the count equals that value, the channel sets a sticky flag. Each flag drives its own level interrupt line.

Software reads the two halves of the count in separate accesses. To get a consistent 64-bit time it reads the high half, then the low half, then the high half again, and retries if the high half changed. Software clears a flag by writing one to that flag's bit in the status register. The bus has no read strobe: read data is a combinational function of the address. Writes take effect at the clock edge where the write enable is high.

Top module: `utmr_top`

## Requirements
- R1: The count is 64 bits wide, resets to zero and increases by exactly one on each tick. It wraps modulo 2^64, and a carry out of the low 32 bits increments the high half.
- R2: A tick occurs on one clock cycle in every PRESCALE cycles, and the count holds its value between ticks.
- R3: Registers decode on byte address bits [4:2], and bits [1:0] are ignored. The map is: status at 0x00, count low at 0x04, count high at 0x08, and compare channel n at 0x0C + 4*n for n = 0..3. A compare register reads back the last value written to it.
- R4: Channel n sets its flag on a tick where the low 32 bits of the count after the increment equal compare n. A count already past the compare value does not set the flag.
- R5: Once set, a flag stays set while the count moves on, until software clears it.
- R6: A write to the status register clears flag n when data bit n is 1. Data bits that are 0 leave their flags unchanged.
- R7: If a clear and a new match for the same channel fall in the same cycle, the flag ends up set.
- R8: Interrupt output irq[n] equals flag n. Status read data carries the flags in bits [3:0], and bits [31:4] read as zero.
- R9: The count registers are read-only, and writes to 0x04 or 0x08 do not change the count.
- R10: Address 0x1C reads as zero, and a write to it changes no register.
- R11: After reset, all compare registers, status flags and interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write enable, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr, zero for an unmapped address |
| irq | output | 4 | Level interrupt per compare channel |

## Verification
The assertions assume that bus_addr and bus_wr are stable at the clock edge and that reset is held long enough for the two-stage release to clear. They also assume that the count never reaches its 32-bit carry during a run, so any change in the high half points to a fault. The bench drives every input on the falling edge and holds each write for exactly one cycle. It places compare targets a few ticks ahead of the count it last read, so every match lands inside the sampled window. The clear-versus-match case is timed by finding a count change first and then counting PRESCALE cycles to the next tick edge.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CNT_W   = 2 * DATA_W;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = ADDR_W - SEL_LSB;

  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CNT_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CNT_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CMP0   = 3'd3;
endpackage

// File: rtl/utmr_rst_sync.sv
module utmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/utmr_prescaler.sv
module utmr_prescaler #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pc_q, pc_d;

      always_comb begin
        tick_o = (pc_q == PW'(DIV - 1));
        pc_d   = tick_o ? '0 : pc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
      end

      // R2: a tick is never followed directly by another tick
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/utmr_counter.sv
module utmr_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_nxt_o = cnt_q + 1'b1;
    cnt_d     = tick_i ? cnt_nxt_o : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: without a tick the count holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R1: a carry out of the low half advances the high half by one
  assert_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (&cnt_q[HALF-1:0])) |=>
      (cnt_q[W-1:HALF] == $past(cnt_q[W-1:HALF]) + 1'b1) && (cnt_q[HALF-1:0] == '0));
endmodule

// File: rtl/utmr_channel.sv
module utmr_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [DW-1:0] cnt_nxt_i,
  input  logic          cmp_we_i,
  input  logic [DW-1:0] cmp_wdata_i,
  input  logic          clr_i,
  output logic [DW-1:0] cmp_o,
  output logic          flag_o
);
  logic [DW-1:0] cmp_q, cmp_d;
  logic          flag_q, flag_d;
  logic          hit;

  always_comb begin
    hit    = tick_i && (cnt_nxt_i == cmp_q);
    cmp_d  = cmp_we_i ? cmp_wdata_i : cmp_q;
    flag_d = hit ? 1'b1 : (clr_i ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;

  // R4: the flag rises only on a tick whose new count equals the compare value
  assert_set_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q ##1 flag_q |-> $past(tick_i && (cnt_nxt_i == cmp_q)));

  // R5: the flag drops only after a clear request
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q ##1 !flag_q |-> $past(clr_i));

  // R7: a match in the same cycle as a clear leaves the flag set
  assert_match_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && tick_i && (cnt_nxt_i == cmp_q)) |=> flag_q);
endmodule

// File: rtl/utmr_top.sv
module utmr_top #(
  parameter int unsigned PRESCALE = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [utmr_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                         bus_wr,
  input  logic [utmr_pkg::DATA_W-1:0]  bus_wdata,
  output logic [utmr_pkg::DATA_W-1:0]  bus_rdata,
  output logic [utmr_pkg::NUM_CH-1:0]  irq
);
  import utmr_pkg::*;

  logic                 rst_q;
  logic                 tick;
  logic [CNT_W-1:0]     cnt_q, cnt_nxt;
  logic [SEL_W-1:0]     sel;
  logic [NUM_CH-1:0]    cmp_we;
  logic [NUM_CH-1:0]    clr_vec;
  logic [NUM_CH-1:0]    flags;
  logic [DATA_W-1:0]    cmp_val [NUM_CH];
  logic                 unused_bits;

  assign sel         = bus_addr[ADDR_W-1:SEL_LSB];
  assign unused_bits = ^{bus_addr[SEL_LSB-1:0], cnt_nxt[CNT_W-1:DATA_W]};

  utmr_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  utmr_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_q),
    .tick_o (tick)
  );

  utmr_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_q),
    .tick_i    (tick),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  always_comb begin
    clr_vec = (bus_wr && (sel == SEL_STATUS)) ? bus_wdata[NUM_CH-1:0] : '0;
  end

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      assign cmp_we[n] = bus_wr && (sel == SEL_W'(int'(SEL_CMP0) + n));

      utmr_channel #(.DW(DATA_W)) u_ch (
        .clk         (clk),
        .rst_n       (rst_q),
        .tick_i      (tick),
        .cnt_nxt_i   (cnt_nxt[DATA_W-1:0]),
        .cmp_we_i    (cmp_we[n]),
        .cmp_wdata_i (bus_wdata),
        .clr_i       (clr_vec[n]),
        .cmp_o       (cmp_val[n]),
        .flag_o      (flags[n])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (sel == SEL_STATUS)      bus_rdata = {{(DATA_W-NUM_CH){1'b0}}, flags};
    else if (sel == SEL_CNT_LO) bus_rdata = cnt_q[DATA_W-1:0];
    else if (sel == SEL_CNT_HI) bus_rdata = cnt_q[CNT_W-1:DATA_W];
    else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (sel == SEL_W'(int'(SEL_CMP0) + n)) bus_rdata = cmp_val[n];
      end
    end
  end

  assign irq = flags;

  // R8: status read data matches the interrupt lines and has clear upper bits
  assert_status_irq_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (sel == SEL_STATUS) |-> (bus_rdata == {{(DATA_W-NUM_CH){1'b0}}, irq}));

  // R9: a write to a count register never loads the written data
  assert_cnt_readonly_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && (sel == SEL_CNT_LO) && !tick) |=> $stable(cnt_q));

  // R10: the unmapped slot reads zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (sel == 3'd7) |-> (bus_rdata == '0));
endmodule

// File: tb/test_utmr_top.sv
module test_utmr_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  utmr_top #(.PRESCALE(DIV)) i_utmr_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wr    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  // returns at the falling edge right after a count change
  task automatic align(output logic [31:0] v);
    logic [31:0] a, b;
    rd(5'h04, a);
    b = a;
    while (b == a) rd(5'h04, b);
    v = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] d, v, c;
    logic [31:0] tgt [4];
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(5'h00, d); check(d == 0, "R11 status", d, 0);
    check(irq == 0, "R11 irq", {28'd0, irq}, 0);
    for (int n = 0; n < 4; n++) begin
      rd(5'(12 + 4*n), d); check(d == 0, "R11 compare", d, 0);
    end
    rd(5'h08, d); check(d == 0, "R1 high half after reset", d, 0);
    rd(5'h1C, d); check(d == 0, "R10 unmapped read", d, 0);

    // R2 exact spacing: stable for DIV-1 cycles then one step
    align(v);
    for (int i = 1; i < DIV; i++) begin
      rd(5'h04, d); check(d == v, "R2 hold between ticks", d, v);
    end
    rd(5'h04, d); check(d == v + 1, "R2 step on tick", d, v + 1);

    // R1 increment over several spans
    for (int k = 1; k <= 7; k += 3) begin
      align(v);
      repeat (k*DIV - 1) @(negedge clk);
      rd(5'h04, d); check(d == v + 32'(k), "R1 count rate", d, v + 32'(k));
    end

    // R3 compare readback with addr[1:0] ignored
    for (int n = 0; n < 4; n++) begin
      wr(5'(12 + 4*n + n%4), 32'hA5000000 ^ (32'h11111111 * 32'(n + 1)));
    end
    for (int n = 0; n < 4; n++) begin
      rd(5'(12 + 4*n), d);
      check(d == (32'hA5000000 ^ (32'h11111111 * 32'(n + 1))), "R3 compare readback", d,
            32'hA5000000 ^ (32'h11111111 * 32'(n + 1)));
    end

    // R4 R5 R8 match timing, per channel
    rd(5'h04, c);
    for (int n = 0; n < 4; n++) begin
      tgt[n] = c + 32'(5 + 2*n);
      wr(5'(12 + 4*n), tgt[n]);
    end
    for (int i = 0; i < 16*DIV; i++) begin
      rd(5'h04, d);
      for (int n = 0; n < 4; n++) begin
        check(irq[n] == (d >= tgt[n]), "R4 R5 irq versus count", {31'd0, irq[n]}, {31'd0, d >= tgt[n]});
      end
    end
    rd(5'h00, d); check(d == 32'hF, "R8 status flags", d, 32'hF);

    // R6 write zero keeps, write one clears
    wr(5'h00, 32'h0);
    rd(5'h00, d); check(d == 32'hF, "R6 zero write", d, 32'hF);
    wr(5'h00, 32'hFFFF_FFF5);
    rd(5'h00, d); check(d == 32'hA, "R6 partial clear", d, 32'hA);
    check(irq == 4'hA, "R8 irq after clear", {28'd0, irq}, 32'hA);
    wr(5'h00, 32'h8);
    rd(5'h00, d); check(d == 32'h2, "R6 single clear", d, 32'h2);

    // R4 compare already passed does not fire
    wr(5'h00, 32'h2);
    repeat (10*DIV) @(negedge clk);
    check(irq == 0, "R4 passed compare", {28'd0, irq}, 0);

    // R9 count registers read-only
    rd(5'h04, v);
    wr(5'h04, 32'hFFFF_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h04, d); check((d >= v) && (d <= v + 3), "R9 low write ignored", d, v);
    rd(5'h08, d); check(d == 0, "R9 high write ignored", d, 0);

    // R10 unmapped write changes nothing
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, d); check(d == 0, "R10 unmapped after write", d, 0);
    rd(5'h00, d); check(d == 0, "R10 status untouched", d, 0);
    for (int n = 0; n < 4; n++) begin
      rd(5'(12 + 4*n), d); check(d == tgt[n], "R10 compare untouched", d, tgt[n]);
    end

    // R7 clear in the very cycle of a new match on channel 1
    rd(5'h04, c);
    wr(5'h10, c + 4);
    repeat (8*DIV) @(negedge clk);
    check(irq[1] == 1'b1, "R4 flag set before R7", {31'd0, irq[1]}, 1);
    rd(5'h04, c);
    wr(5'h10, c + 4);
    v = c;
    while (v != c + 3) rd(5'h04, v);
    repeat (DIV - 1) @(negedge clk);
    bus_addr = 5'h00; bus_wr = 1'b1; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check(irq[1] == 1'b1, "R7 match wins over clear", {31'd0, irq[1]}, 1);
    rd(5'h04, d); check(d == c + 4, "R7 count at match", d, c + 4);

    // R6 clear on a non-tick cycle takes effect
    align(v);
    bus_addr = 5'h00; bus_wr = 1'b1; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check(irq[1] == 1'b0, "R6 clear off tick", {31'd0, irq[1]}, 0);

    finish_run();
  end
endmodule